// File: doc/BRIEF.md
# Reset-Time Configuration Byte Loader

After every reset, this block walks a small stored configuration area of eight byte pairs. It fetches one pair per read from a simple read port and compares the value byte with its complement byte. It then keeps the result in output registers. A pair whose bytes are not complements of each other is replaced by 0xFF and marks a sticky error. The one exception is an erased pair, with both bytes 0xFF, which is taken as 0xFF with no error.

The first pair holds the security byte, which is decoded into three protection levels. The first four pairs drive a status bus. The last four pairs form a 32-bit write-protection word.

The outputs only carry loaded values once `load_done` is high. Before that they show the safe defaults, so that the rest of the chip can be held off until loading finishes.

Top module: `cfg_byte_loader`

## Requirements
- R1: After reset is released, the block issues exactly eight reads on consecutive cycles at addresses 0,1,...,7 in ascending order, and it issues no further read while `load_done` is high.
- R2: The read port has a latency of one cycle. Data for the address presented with `rd_req` in one cycle is sampled from `rd_data` at the following clock edge, with the value byte in `rd_data[7:0]` and the complement byte in `rd_data[15:8]`.
- R3: When the complement byte equals the bitwise inverse of the value byte, the value byte is loaded unchanged.
- R4: When the two bytes are not complements and the pair is not erased, the loaded byte becomes 0xFF and `err_flag` reads 1 once loading is done.
- R5: An erased pair, with both bytes 0xFF, loads as 0xFF and does not set `err_flag`.
- R6: `err_flag` records a failure in any of the eight pairs and stays high until the next reset.
- R7: `prot_lvl` decodes the loaded byte of pair 0 as follows: 0xA5 gives 0 (none), 0xCC gives 2 (high), and any other value gives 1 (low). A pair 0 that was forced to 0xFF therefore gives low.
- R8: Pair n for n = 0..3 appears on `opt_stat[8n+7:8n]`, and pair 4+n appears on `wp_word[8n+7:8n]`.
- R9: `load_done` rises two cycles after the cycle in which the eighth read is requested. It then stays high, with all loaded outputs stable, until reset.
- R10: While `load_done` is low, `opt_stat` and `wp_word` read all ones, `err_flag` reads 0 and `prot_lvl` reads 2.
- R11: A reset asserted part-way through loading discards the partial result, and loading restarts from pair 0 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req | output | 1 | Read strobe to the configuration store |
| rd_addr | output | 3 | Pair index being read |
| rd_data | input | 16 | Pair returned one cycle after the request: complement in [15:8], value in [7:0] |
| load_done | output | 1 | Loading finished; outputs valid |
| err_flag | output | 1 | Sticky complement-check failure |
| prot_lvl | output | 2 | Protection level: 0 none, 1 low, 2 high |
| opt_stat | output | 32 | Loaded pairs 0..3 |
| wp_word | output | 32 | Loaded pairs 4..7 (write protection) |

## Verification
The check of the eighth pair and the assertion of `load_done` happen at the same clock edge. A failure in that pair must therefore raise `err_flag` in exactly the cycle in which `load_done` rises, and never one cycle late. One scenario corrupts only the last pair, and another reads an erased pair next to a corrupted one. A behavioural model in the bench tracks the responses it served and predicts every output on every cycle, so an error that appears late, early, or against the wrong pair is caught in that very cycle.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_LOW  = 2'd1,
    PROT_HIGH = 2'd2
  } prot_e;

  localparam logic [7:0] SEC_OPEN_CODE = 8'hA5;
  localparam logic [7:0] SEC_HIGH_CODE = 8'hCC;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_pair_check.sv
module cfg_pair_check #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] val_i,
  input  logic [BYTE_W-1:0] cmp_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              bad_o
);
  logic match;
  logic erased;

  always_comb begin
    match  = (cmp_i == ~val_i);
    erased = (&val_i) && (&cmp_i);
    byte_o = match ? val_i : {BYTE_W{1'b1}};
    bad_o  = !match && !erased;
  end
endmodule

// File: rtl/cfg_prot_decode.sv
module cfg_prot_decode
  import cfg_ld_pkg::*;
(
  input  logic [7:0] sec_byte_i,
  output prot_e      level_o
);
  always_comb begin
    if (sec_byte_i == SEC_OPEN_CODE)      level_o = PROT_NONE;
    else if (sec_byte_i == SEC_HIGH_CODE) level_o = PROT_HIGH;
    else                                  level_o = PROT_LOW;
  end
endmodule

// File: rtl/cfg_ld_seq.sv
module cfg_ld_seq #(
  parameter int NUM_PAIRS = 8,
  localparam int AW = $clog2(NUM_PAIRS),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          cap_vld,
  output logic [AW-1:0] cap_idx,
  output logic          done
);
  localparam logic [CW-1:0] ISSUE_END = CW'(NUM_PAIRS);
  localparam logic [AW-1:0] LAST_IDX  = AW'(NUM_PAIRS - 1);

  logic          run_q,  run_d;
  logic [CW-1:0] iss_q,  iss_d;
  logic          vld_q,  vld_d;
  logic [AW-1:0] idx_q,  idx_d;
  logic          done_q, done_d;

  assign rd_req  = run_q && (iss_q != ISSUE_END);
  assign rd_addr = iss_q[AW-1:0];

  always_comb begin
    run_d  = 1'b1;
    iss_d  = rd_req ? iss_q + 1'b1 : iss_q;
    vld_d  = rd_req;
    idx_d  = rd_req ? iss_q[AW-1:0] : idx_q;
    done_d = done_q || (vld_q && (idx_q == LAST_IDX));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      iss_q  <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      iss_q  <= iss_d;
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign cap_vld = vld_q;
  assign cap_idx = idx_q;
  assign done    = done_q;
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfg_ld_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int WP_PAIRS  = 4,
  parameter int BYTE_W    = 8,
  localparam int AW         = $clog2(NUM_PAIRS),
  localparam int STAT_PAIRS = NUM_PAIRS - WP_PAIRS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         rd_req,
  output logic [AW-1:0]                rd_addr,
  input  logic [2*BYTE_W-1:0]          rd_data,
  output logic                         load_done,
  output logic                         err_flag,
  output logic [1:0]                   prot_lvl,
  output logic [STAT_PAIRS*BYTE_W-1:0] opt_stat,
  output logic [WP_PAIRS*BYTE_W-1:0]   wp_word
);
  logic          rst_ni;
  logic          cap_vld;
  logic [AW-1:0] cap_idx;
  logic          done;
  logic [BYTE_W-1:0] chk_byte;
  logic          chk_bad;
  logic          err_q, err_d;
  prot_e         dec_lvl;
  logic [BYTE_W-1:0] byte_q [NUM_PAIRS];

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  cfg_ld_seq #(.NUM_PAIRS(NUM_PAIRS)) u_seq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .cap_vld (cap_vld),
    .cap_idx (cap_idx),
    .done    (done)
  );

  cfg_pair_check #(.BYTE_W(BYTE_W)) u_chk (
    .val_i  (rd_data[BYTE_W-1:0]),
    .cmp_i  (rd_data[2*BYTE_W-1:BYTE_W]),
    .byte_o (chk_byte),
    .bad_o  (chk_bad)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic              we;
    logic [BYTE_W-1:0] nxt;

    assign we = cap_vld && (cap_idx == AW'(p));
    always_comb nxt = we ? chk_byte : byte_q[p];

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) byte_q[p] <= {BYTE_W{1'b1}};
      else         byte_q[p] <= nxt;
    end

    if (p < STAT_PAIRS) begin : g_stat
      assign opt_stat[p*BYTE_W +: BYTE_W] = done ? byte_q[p] : {BYTE_W{1'b1}};
    end else begin : g_wp
      assign wp_word[(p-STAT_PAIRS)*BYTE_W +: BYTE_W] = done ? byte_q[p] : {BYTE_W{1'b1}};
    end
  end

  always_comb err_d = err_q || (cap_vld && chk_bad);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  cfg_prot_decode u_dec (
    .sec_byte_i (byte_q[0][7:0]),
    .level_o    (dec_lvl)
  );

  assign load_done = done;
  assign err_flag  = done && err_q;
  assign prot_lvl  = done ? dec_lvl : PROT_HIGH;
endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk
  import cfg_ld_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int WP_PAIRS  = 4,
  parameter int BYTE_W    = 8,
  localparam int AW         = $clog2(NUM_PAIRS),
  localparam int STAT_PAIRS = NUM_PAIRS - WP_PAIRS
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_req,
  input logic [AW-1:0]                rd_addr,
  input logic                         load_done,
  input logic                         err_flag,
  input logic [1:0]                   prot_lvl,
  input logic [STAT_PAIRS*BYTE_W-1:0] opt_stat,
  input logic [WP_PAIRS*BYTE_W-1:0]   wp_word
);
  AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> rd_addr == '0);  // R1
  AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && $past(rd_req) |-> rd_addr == $past(rd_addr) + 1'b1);  // R1
  AST_NO_READ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !rd_req);  // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);  // R6
  AST_HIGH_CODE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && opt_stat[7:0] == SEC_HIGH_CODE |-> prot_lvl == PROT_HIGH);  // R7
  AST_OPEN_CODE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && opt_stat[7:0] == SEC_OPEN_CODE |-> prot_lvl == PROT_NONE);  // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done && $stable(opt_stat) && $stable(wp_word));  // R9
  AST_OUTPUTS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> prot_lvl == PROT_HIGH && !err_flag && (&opt_stat) && (&wp_word));  // R10
endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .WP_PAIRS  (WP_PAIRS),
  .BYTE_W    (BYTE_W)
) u_props (.*);

// File: tb/cfg_byte_loader_test.sv
module cfg_byte_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data = 16'h0;
  logic        load_done, err_flag;
  logic [1:0]  prot_lvl;
  logic [31:0] opt_stat, wp_word;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cfg_byte_loader uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .load_done(load_done), .err_flag(err_flag), .prot_lvl(prot_lvl),
    .opt_stat(opt_stat), .wp_word(wp_word)
  );

  always #10 clk = ~clk;

  logic [15:0] mem [8];

  // behavioural reference model state
  bit       req_seen;
  int       addr_seen;
  bit       pend;
  int       pend_idx;
  bit       m_done, m_err;
  bit [7:0] m_byte [8];
  int       next_addr, reads, last_req_cyc, done_cyc;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit [1:0] decode(input bit [7:0] b);
    if (b == 8'hA5) return 2'd0;
    if (b == 8'hCC) return 2'd2;
    return 2'd1;
  endfunction

  function automatic bit [7:0] want_byte(input logic [15:0] w);
    return (w[15:8] == ~w[7:0]) ? w[7:0] : 8'hFF;
  endfunction

  function automatic logic [15:0] good(input logic [7:0] b);
    return {~b, b};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = 0; m_done = 0; m_err = 0;
      foreach (m_byte[i]) m_byte[i] = 8'hFF;
    end else begin
      if (pend) begin
        bit [7:0] lo, hi;
        lo = mem[pend_idx][7:0];
        hi = mem[pend_idx][15:8];
        if (hi == ~lo) m_byte[pend_idx] = lo;
        else begin
          m_byte[pend_idx] = 8'hFF;
          if (!(lo == 8'hFF && hi == 8'hFF)) m_err = 1;
        end
        if (pend_idx == 7) m_done = 1;
      end
      pend = req_seen;
      pend_idx = addr_seen;
      if (req_seen) rd_data <= mem[addr_seen];
    end
  end

  always @(negedge clk) begin
    logic [31:0] es, ew;
    cyc++;
    es = m_done ? {m_byte[3], m_byte[2], m_byte[1], m_byte[0]} : 32'hFFFF_FFFF;
    ew = m_done ? {m_byte[7], m_byte[6], m_byte[5], m_byte[4]} : 32'hFFFF_FFFF;
    if (!rst_n) begin
      next_addr = 0; reads = 0; done_cyc = -1;
    end else begin
      // per-cycle comparison against the model (R9 when done, R10 before)
      chk({load_done, err_flag, prot_lvl, opt_stat, wp_word} ==
          {m_done, m_done & m_err, (m_done ? decode(m_byte[0]) : 2'd2), es, ew},
          m_done ? "R9 cycle" : "R10 cycle",
          {load_done, err_flag, prot_lvl, opt_stat[23:0], wp_word[23:0]},
          {m_done, m_done & m_err, (m_done ? decode(m_byte[0]) : 2'd2), es[23:0], ew[23:0]});
      if (rd_req) begin
        chk(rd_addr == 3'(next_addr), "R1 addr", rd_addr, next_addr);
        next_addr++; reads++; last_req_cyc = cyc;
      end
      if (load_done && done_cyc < 0) done_cyc = cyc;
    end
    req_seen  = rd_req;
    addr_seen = rd_addr;
  end

  task automatic do_reset(input int n);
    @(negedge clk); rst_n = 0;
    repeat (n) @(negedge clk);
    chk(!load_done && !rd_req && prot_lvl == 2'd2, "R10 reset", {load_done, rd_req, prot_lvl}, 4'b0010);
    rst_n = 1;
  endtask

  task automatic run(input string name, input bit [1:0] exp_prot, input bit exp_err);
    logic [31:0] es, ew;
    do_reset(3);
    repeat (30) @(negedge clk);
    es = {want_byte(mem[3]), want_byte(mem[2]), want_byte(mem[1]), want_byte(mem[0])};
    ew = {want_byte(mem[7]), want_byte(mem[6]), want_byte(mem[5]), want_byte(mem[4])};
    chk(reads == 8 && !rd_req, {"R1 read count ", name}, reads, 8);
    chk(done_cyc - last_req_cyc == 2, {"R9 R2 done timing ", name}, done_cyc - last_req_cyc, 2);
    chk(opt_stat == es, {"R3 R4 R5 R8 status ", name}, opt_stat, es);
    chk(wp_word == ew, {"R3 R4 R5 R8 wp ", name}, wp_word, ew);
    chk(err_flag == exp_err, {"R4 R5 R6 error ", name}, err_flag, exp_err);
    chk(prot_lvl == exp_prot, {"R7 protection ", name}, prot_lvl, exp_prot);
  endtask

  task automatic fill(input logic [7:0] sec);
    mem[0] = good(sec);
    for (int i = 1; i < 8; i++) mem[i] = good(8'(8'h11 * i + 8'h03));
  endtask

  initial begin
    fork
      begin
        fill(8'hA5);                          run("open", 2'd0, 1'b0);
        fill(8'hCC);                          run("high", 2'd2, 1'b0);
        fill(8'h3C);                          run("low", 2'd1, 1'b0);
        foreach (mem[i]) mem[i] = 16'hFFFF;   run("erased", 2'd1, 1'b0);       // R5
        fill(8'hA5); mem[0] = 16'h00A5;       run("bad sec", 2'd1, 1'b1);      // R4 R7
        fill(8'hA5); mem[7] = 16'h1234;       run("bad last", 2'd0, 1'b1);     // R6
        fill(8'hCC); mem[3] = 16'h00FF; mem[4] = 16'hFFFF; mem[5] = 16'hFF12;
        run("mixed", 2'd2, 1'b1);
        // R11: reset part-way, then a clean image must load from pair 0
        fill(8'hA5); mem[2] = 16'h0000;
        do_reset(2);
        repeat (6) @(negedge clk);
        fill(8'h5A);
        run("R11 restart", 2'd1, 1'b0);
      end
      begin
        repeat (5000) @(negedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule